// File: doc/BRIEF.md
# Static LCD Backplane and Segment Driver

This block drives a static (non-multiplexed) liquid crystal display showing three full seven-segment digits, a leading half-digit "1" and a minus sign. A converter supplies a latched reading: three BCD digits, a flag for the leading "1", a flag for a negative reading and a flag for overrange. The block decodes the digits to segment patterns and drives every segment pin with an AC waveform, so that the glass never sees a DC bias.

One free-running divider makes a 50% duty square wave on the backplane pin. Its period is 800 system clocks. Each segment pin carries the backplane wave when the segment is dark and the inverted wave when it is lit. The reading is captured only on backplane transitions, so a segment pin never changes level inside a half-period. The leading "1" uses two glass segments that share one enable. An overrange reading blanks the three low digits and keeps the "1" and the sign visible.

Top module: `lcd_static_drv`

## Requirements
- R1: `backplane` is low during reset. It then inverts after every HALF_CNT (default 400) rising clock edges, which gives a 50% duty square wave with a period of 2*HALF_CNT clocks.
- R2: A dark segment output has the same level as `backplane` at all times.
- R3: A lit segment output has the opposite level to `backplane` at all times.
- R4: Digit d takes BCD bits digitBcd[4d+3:4d], with d=0 the units digit. Its segments are segOut[7d+6:7d], in the order a=bit0, b=bit1, c=bit2, d=bit3, e=bit4, f=bit5, g=bit6. The lit sets, written as 7-bit hex, are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F.
- R5: BCD codes 10 to 15 on a digit leave all seven segments of that digit dark.
- R6: `signSegOut` is lit when `isNegative` is 1 and dark when it is 0.
- R7: The two bits of `leadSegOut` are always equal. They are lit when `leadOne` is 1.
- R8: When `overRange` is 1, all segments of the three low digits are dark, both `leadSegOut` bits are lit whatever `leadOne` is, and the sign still follows `isNegative`.
- R9: Inputs are captured only at the clock edge where `backplane` inverts. An input change between two such edges has no effect on any output until the next inversion.
- R10: During reset every segment output is low, which is the dark state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| digitBcd | input | 12 | Three BCD digits; bits 3:0 hold the units digit |
| leadOne | input | 1 | Show the leading "1" |
| isNegative | input | 1 | The reading is negative; light the minus sign |
| overRange | input | 1 | The reading is out of range; blank the low digits |
| backplane | output | 1 | Backplane square wave |
| segOut | output | 21 | Segment pins a..g of the three low digits |
| leadSegOut | output | 2 | The two segment pins of the leading "1" |
| signSegOut | output | 1 | Minus-sign segment pin |

## Verification
The display contents can be read at the ports as segOut XOR backplane. A wrong decode or a wrong overrange mask therefore shows up as a wrong lit pattern in the first half-period after the next backplane inversion, which is at most HALF_CNT clocks after the input changes. A wrong divider count shows as a backplane interval other than HALF_CNT clocks, visible at the first inversion after reset. A wrong capture strobe shows as a segment pin that moves while the backplane holds its level, so the pin sits at DC relative to the backplane for part of a half-period.

// File: rtl/lcd_static_pkg.sv
package lcd_static_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic bpFlip;    // invert the backplane on this edge
    logic dataLoad;  // capture the reading on this edge
  } ctrlStrobe_t;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  // Lit-segment set for one BCD digit, a=bit0 .. g=bit6; codes above 9 are dark
  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_static_ctrl.sv
module lcd_static_ctrl
  import lcd_static_pkg::*;
#(
  parameter int HALF_CNT = 400
) (
  input  logic        clk,
  input  logic        rstN,
  output ctrlStrobe_t strobe
);
  localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

  logic [CW-1:0] halfCnt;
  logic          halfDone;

  assign halfDone = (halfCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfCnt <= '0;
    else if (halfDone) halfCnt <= '0;
    else halfCnt <= halfCnt + 1'b1;
  end

  // The reading is captured on the same edge as the backplane inversion
  assign strobe.bpFlip   = halfDone;
  assign strobe.dataLoad = halfDone;
endmodule

// File: rtl/lcd_static_datapath.sv
module lcd_static_datapath
  import lcd_static_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [NUM_DIGITS*BCD_W-1:0] digitBcd,
  input  logic                        leadOne,
  input  logic                        isNegative,
  input  logic                        overRange,
  output logic                        backplane,
  output logic [NUM_DIGITS*SEG_W-1:0] segOut,
  output logic [1:0]                  leadSegOut,
  output logic                        signSegOut
);
  localparam int ALL_SEG = NUM_DIGITS * SEG_W;

  logic [ALL_SEG-1:0] digEnNext;
  logic [ALL_SEG-1:0] digEnQ;
  logic               leadEnQ;
  logic               signEnQ;
  logic               bpQ;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    always_comb begin
      if (overRange) digEnNext[d*SEG_W +: SEG_W] = '0;
      else digEnNext[d*SEG_W +: SEG_W] = bcdToSeg(digitBcd[d*BCD_W +: BCD_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ     <= 1'b0;
      digEnQ  <= '0;
      leadEnQ <= 1'b0;
      signEnQ <= 1'b0;
    end else begin
      if (strobe.bpFlip) bpQ <= ~bpQ;
      if (strobe.dataLoad) begin
        digEnQ  <= digEnNext;
        leadEnQ <= leadOne | overRange;
        signEnQ <= isNegative;
      end
    end
  end

  // A lit segment is driven in antiphase with the backplane
  assign backplane  = bpQ;
  assign segOut     = digEnQ ^ {ALL_SEG{bpQ}};
  assign leadSegOut = {2{leadEnQ ^ bpQ}};
  assign signSegOut = signEnQ ^ bpQ;
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_static_pkg::*;
#(
  parameter int HALF_CNT   = 400,
  parameter int NUM_DIGITS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_DIGITS*4-1:0]     digitBcd,
  input  logic                        leadOne,
  input  logic                        isNegative,
  input  logic                        overRange,
  output logic                        backplane,
  output logic [NUM_DIGITS*7-1:0]     segOut,
  output logic [1:0]                  leadSegOut,
  output logic                        signSegOut
);
  ctrlStrobe_t strobe;

  lcd_static_ctrl #(.HALF_CNT(HALF_CNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  lcd_static_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .digitBcd(digitBcd), .leadOne(leadOne), .isNegative(isNegative),
    .overRange(overRange), .backplane(backplane), .segOut(segOut),
    .leadSegOut(leadSegOut), .signSegOut(signSegOut)
  );
endmodule

// File: rtl/lcd_static_chk.sv
module lcd_static_chk #(
  parameter int HALF_CNT   = 400,
  parameter int NUM_DIGITS = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    isNegative,
  input logic                    overRange,
  input logic                    backplane,
  input logic [NUM_DIGITS*7-1:0] segOut,
  input logic [1:0]              leadSegOut,
  input logic                    signSegOut
);
  localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;

  // Independent count of edges since reset, modulo HALF_CNT
  logic [CW-1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt == CW'(HALF_CNT - 1)) edgeCnt <= '0;
    else edgeCnt <= edgeCnt + 1'b1;
  end

  // R1: inversion exactly after each HALF_CNT edges
  a_r1_bp_flips: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == CW'(HALF_CNT - 1)) |=> !$stable(backplane));
  a_r1_bp_holds: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt != CW'(HALF_CNT - 1)) |=> $stable(backplane));

  // R9: segment pins move only together with the backplane
  a_r9_no_midhalf_change: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(segOut) || !$stable(leadSegOut) || !$stable(signSegOut)) |-> !$stable(backplane));

  // R6: sign captured at the inversion edge
  a_r6_sign: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(backplane) |-> ((signSegOut != backplane) == $past(isNegative)));

  // R7: the two lead pins share one enable
  a_r7_lead_pair: assert property (@(posedge clk) disable iff (!rstN)
    leadSegOut[0] == leadSegOut[1]);

  // R8: overrange blanks the low digits and lights the lead
  a_r8_overrange: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(backplane) && $past(overRange)) |->
      (segOut == {(NUM_DIGITS*7){backplane}} && leadSegOut == {2{~backplane}}));
endmodule

bind lcd_static_drv lcd_static_chk #(.HALF_CNT(HALF_CNT), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rstN(rstN), .isNegative(isNegative), .overRange(overRange),
  .backplane(backplane), .segOut(segOut), .leadSegOut(leadSegOut), .signSegOut(signSegOut)
);

// File: tb/lcd_static_drv_bench.sv
module lcd_static_drv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] digitBcd = '0;
  logic        leadOne = 1'b0, isNegative = 1'b0, overRange = 1'b0;
  logic        backplane;
  logic [20:0] segOut;
  logic [1:0]  leadSegOut;
  logic        signSegOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_static_drv u_lcd_static_drv (
    .clk(clk), .rstN(rstN), .digitBcd(digitBcd), .leadOne(leadOne),
    .isNegative(isNegative), .overRange(overRange), .backplane(backplane),
    .segOut(segOut), .leadSegOut(leadSegOut), .signSegOut(signSegOut)
  );

  // Expected pattern, taken from the R4/R5 table
  function automatic logic [6:0] expPat(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setIn(input int d2, input int d1, input int d0,
                       input logic lo, input logic neg, input logic ovr);
    @(negedge clk);
    digitBcd   = {4'(d2), 4'(d1), 4'(d0)};
    leadOne    = lo;
    isNegative = neg;
    overRange  = ovr;
  endtask

  task automatic waitToggle();
    @(backplane);
    repeat (2) @(negedge clk);
  endtask

  // Compares pins with the wanted lit set (R2 dark = bp, R3 lit = ~bp)
  task automatic checkShow(input string req, input logic [20:0] litDig,
                           input logic litLead, input logic litSign);
    check({req, " seg"},  32'(segOut), 32'(litDig ^ {21{backplane}}));
    check({req, " lead"}, 32'(leadSegOut), 32'({2{litLead ^ backplane}}));
    check({req, " sign"}, 32'(signSegOut), 32'(litSign ^ backplane));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R10 reset bp", 32'(backplane), 32'd0);
    check("R10 reset seg", 32'({segOut, leadSegOut, signSegOut}), 32'd0);
    rstN = 1'b1;
  endtask

  task automatic testPeriod();
    for (int k = 0; k < 2; k++) begin
      logic prev;
      int n;
      @(backplane);
      prev = backplane;
      n = 0;
      do begin
        @(posedge clk); #1; n++;
      end while (backplane == prev && n < 2000);
      check("R1 half period", 32'(n), 32'(HALF));
    end
  endtask

  task automatic testDigits();
    for (int v = 0; v < 10; v++) begin
      int a = (v + 3) % 10;
      int b = (v + 7) % 10;
      setIn(b, a, v, 1'b0, 1'b0, 1'b0);
      for (int ph = 0; ph < 2; ph++) begin
        waitToggle();
        checkShow("R4 R2 R3 decode", {expPat(b), expPat(a), expPat(v)}, 1'b0, 1'b0);
      end
    end
  endtask

  task automatic testInvalid();
    for (int v = 10; v < 16; v++) begin
      setIn(v, 8, v, 1'b0, 1'b0, 1'b0);
      waitToggle();
      checkShow("R5 invalid code", {7'h00, 7'h7F, 7'h00}, 1'b0, 1'b0);
    end
  endtask

  task automatic testSignLead();
    setIn(1, 2, 3, 1'b1, 1'b1, 1'b0);
    waitToggle();
    checkShow("R6 R7 sign lead on", {expPat(1), expPat(2), expPat(3)}, 1'b1, 1'b1);
    waitToggle();
    checkShow("R6 R7 sign lead other phase", {expPat(1), expPat(2), expPat(3)}, 1'b1, 1'b1);
    setIn(1, 2, 3, 1'b0, 1'b1, 1'b0);
    waitToggle();
    checkShow("R7 lead off", {expPat(1), expPat(2), expPat(3)}, 1'b0, 1'b1);
    setIn(1, 2, 3, 1'b1, 1'b0, 1'b0);
    waitToggle();
    checkShow("R6 sign off", {expPat(1), expPat(2), expPat(3)}, 1'b1, 1'b0);
  endtask

  task automatic testOverRange();
    setIn(8, 8, 8, 1'b0, 1'b1, 1'b1);
    waitToggle();
    checkShow("R8 overrange neg", 21'd0, 1'b1, 1'b1);
    waitToggle();
    checkShow("R8 overrange other phase", 21'd0, 1'b1, 1'b1);
    setIn(5, 0, 9, 1'b1, 1'b0, 1'b1);
    waitToggle();
    checkShow("R8 overrange pos", 21'd0, 1'b1, 1'b0);
    setIn(5, 0, 9, 1'b1, 1'b0, 1'b0);
    waitToggle();
    checkShow("R8 overrange cleared", {expPat(5), expPat(0), expPat(9)}, 1'b1, 1'b0);
  endtask

  task automatic testMidHalf();
    setIn(4, 5, 6, 1'b0, 1'b0, 1'b0);
    waitToggle();
    repeat (10) @(negedge clk);
    setIn(7, 7, 7, 1'b1, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    checkShow("R9 change ignored mid half", {expPat(4), expPat(5), expPat(6)}, 1'b0, 1'b0);
    waitToggle();
    checkShow("R9 change taken at inversion", {expPat(7), expPat(7), expPat(7)}, 1'b1, 1'b1);
  endtask

  initial begin
    testReset();
    testPeriod();
    testDigits();
    testInvalid();
    testSignLead();
    testOverRange();
    testMidHalf();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule